// File: doc/BRIEF.md
# DMA Channel Arbiter with Interrupt Veto

This block decides which of several DMA channels gets the system bus and when the bus is handed over. Each channel raises a level-sensitive request. The arbiter picks the most important one, asks the CPU for the bus with a hold request, and waits for the hold acknowledge. Only then does it show a one-hot grant to the transfer engine. The grant stays on that channel until the engine reports that the transfer is done. The bus always returns to the CPU between two grants, so a later channel is never chained directly onto an earlier one.

An interrupt veto sits on top of the arbitration. The interrupt controller supplies the level of its most urgent pending request, qualified by a valid flag. Levels run from 0 to 31, and a lower number is more urgent. A programmable cancel threshold decides which of those levels are urgent enough to keep DMA off the bus. When the veto arises during a transfer, the transfer stops at the engine's next break point and the bus is released. The cancelled channel is reported through a one-cycle abort pulse. The arbiter does not clear that channel's request, so the channel competes again once the veto lifts.

Top module: `dma_hold_arbiter`

## Requirements
- R1: After reset, holdReq, chGrant and abortPulse are all 0, and the arbiter is idle.
- R2: Priority is fixed by channel index. Among the pending chReq bits, the lowest index wins. chGrant bit i set means channel i is granted.
- R3: chGrant is one-hot or zero. While a grant is shown, new or higher-priority requests do not change it until xferDone or a cancel.
- R4: holdReq rises one cycle after a request is accepted. chGrant stays 0 until holdAck is seen high, and appears one cycle after that.
- R5: On xferDone, holdReq and chGrant drop in the next cycle. holdReq stays low at least until holdAck has been seen low, plus one idle cycle, before the next hold request.
- R6: The veto is active when irqValid is 1 and irqLevel is numerically less than the cancel threshold. While the veto is active in the idle state, no hold request is raised, whatever chReq holds.
- R7: During a grant, xferBreak has no effect unless the veto is active. With the veto active, the veto has no effect until xferBreak. On xferBreak with the veto active, holdReq and chGrant drop in the next cycle, and abortPulse is 1 for exactly that one cycle with abortCh holding the cancelled channel's index.
- R8: The cancel threshold resets to 31. A write with cfgWrEn loads cfgWrData. An interrupt at level 31 never vetoes, and any level from 0 to 30 vetoes after reset.
- R9: With irqValid at 0, no veto applies at any irqLevel. When the veto lifts, pending requests are served again.
- R10: A cancelled channel whose request is still held is granted again once the veto lifts.
- R11: If the veto arises while waiting for holdAck, holdReq is withdrawn in the next cycle and no abort pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chReq | input | NUM_CH | Per-channel transfer requests, level sensitive |
| holdAck | input | 1 | CPU has released the bus |
| xferDone | input | 1 | Transfer engine finished the granted transfer |
| xferBreak | input | 1 | Transfer engine is at a point where it may stop |
| irqValid | input | 1 | An interrupt is pending and irqLevel is meaningful |
| irqLevel | input | LVL_W | Level of the most urgent pending interrupt, 0 most urgent |
| cfgWrEn | input | 1 | Write strobe for the cancel threshold |
| cfgWrData | input | LVL_W | New cancel threshold |
| holdReq | output | 1 | Bus hold request to the CPU |
| chGrant | output | NUM_CH | One-hot grant to the transfer engine |
| abortPulse | output | 1 | One-cycle pulse when a transfer is cancelled |
| abortCh | output | CH_W | Index of the cancelled channel |

## Verification
The bench uses the default build: eight channels and five-bit levels. With eight channels, both ends of the priority order and a higher-priority request arriving mid-grant can be driven. With five-bit levels, the reset threshold of 31 can be exercised at its edge: level 30 vetoes and level 31 does not. A written threshold of 10 is then probed on both sides. The cancel path, the withdrawal of a pending hold, and the re-grant of a cancelled channel are driven as separate scenarios.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_HOLD_REQ = 2'd1,
    ST_XFER     = 2'd2,
    ST_RELEASE  = 2'd3
  } arbState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic latchWinner;  // capture the arbitration winner
    logic showGrant;    // drive the one-hot grant
    logic cancelEvt;    // transfer cancelled at a break point
  } arbStrobe_t;

endpackage

// File: rtl/dma_arb_datapath.sv
module dma_arb_datapath
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int LVL_W  = 5,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chReq,
  input  logic              irqValid,
  input  logic [LVL_W-1:0]  irqLevel,
  input  logic              cfgWrEn,
  input  logic [LVL_W-1:0]  cfgWrData,
  input  arbStrobe_t        strobe,
  output logic              anyReq,
  output logic              suppress,
  output logic [NUM_CH-1:0] chGrant,
  output logic              abortPulse,
  output logic [CH_W-1:0]   abortCh
);

  localparam logic [LVL_W-1:0] RESET_LVL = {LVL_W{1'b1}};

  logic [LVL_W-1:0] cancelLvl;
  logic [CH_W-1:0]  winIdx;
  logic [CH_W-1:0]  grantIdx;

  // Cancel threshold register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cancelLvl <= RESET_LVL;
    else if (cfgWrEn) cancelLvl <= cfgWrData;
  end

  // Veto: a valid interrupt more urgent than the threshold
  assign suppress = irqValid && (irqLevel < cancelLvl);

  // Fixed priority: the lowest index wins
  always_comb begin
    winIdx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (chReq[i]) winIdx = CH_W'(i);
    end
  end

  assign anyReq = |chReq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  grantIdx <= '0;
    else if (strobe.latchWinner) grantIdx <= winIdx;
  end

  assign chGrant = strobe.showGrant ? (NUM_CH'(1) << grantIdx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abortPulse <= 1'b0;
      abortCh    <= '0;
    end else begin
      abortPulse <= strobe.cancelEvt;
      if (strobe.cancelEvt) abortCh <= grantIdx;
    end
  end

endmodule

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       anyReq,
  input  logic       suppress,
  input  logic       holdAck,
  input  logic       xferDone,
  input  logic       xferBreak,
  output logic       holdReq,
  output arbStrobe_t strobe
);

  arbState_t state, stateNxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      ST_IDLE: begin
        if (anyReq && !suppress) begin
          strobe.latchWinner = 1'b1;
          stateNxt           = ST_HOLD_REQ;
        end
      end
      ST_HOLD_REQ: begin
        if (suppress)     stateNxt = ST_RELEASE;
        else if (holdAck) stateNxt = ST_XFER;
      end
      ST_XFER: begin
        strobe.showGrant = 1'b1;
        if (xferDone) begin
          stateNxt = ST_RELEASE;
        end else if (xferBreak && suppress) begin
          strobe.cancelEvt = 1'b1;
          stateNxt         = ST_RELEASE;
        end
      end
      ST_RELEASE: begin
        if (!holdAck) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign holdReq = (state == ST_HOLD_REQ) || (state == ST_XFER);

endmodule

// File: rtl/dma_hold_arbiter.sv
module dma_hold_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int LVL_W  = 5,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chReq,
  input  logic              holdAck,
  input  logic              xferDone,
  input  logic              xferBreak,
  input  logic              irqValid,
  input  logic [LVL_W-1:0]  irqLevel,
  input  logic              cfgWrEn,
  input  logic [LVL_W-1:0]  cfgWrData,
  output logic              holdReq,
  output logic [NUM_CH-1:0] chGrant,
  output logic              abortPulse,
  output logic [CH_W-1:0]   abortCh
);

  arbStrobe_t strobe;
  logic       anyReq;
  logic       suppress;

  dma_arb_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .anyReq    (anyReq),
    .suppress  (suppress),
    .holdAck   (holdAck),
    .xferDone  (xferDone),
    .xferBreak (xferBreak),
    .holdReq   (holdReq),
    .strobe    (strobe)
  );

  dma_arb_datapath #(
    .NUM_CH (NUM_CH),
    .LVL_W  (LVL_W)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .chReq      (chReq),
    .irqValid   (irqValid),
    .irqLevel   (irqLevel),
    .cfgWrEn    (cfgWrEn),
    .cfgWrData  (cfgWrData),
    .strobe     (strobe),
    .anyReq     (anyReq),
    .suppress   (suppress),
    .chGrant    (chGrant),
    .abortPulse (abortPulse),
    .abortCh    (abortCh)
  );

endmodule

// File: rtl/dma_hold_arbiter_chk.sv
module dma_hold_arbiter_chk #(
  parameter int NUM_CH = 8,
  parameter int LVL_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xferDone,
  input logic              xferBreak,
  input logic              irqValid,
  input logic [LVL_W-1:0]  irqLevel,
  input logic              cfgWrEn,
  input logic [LVL_W-1:0]  cfgWrData,
  input logic              holdReq,
  input logic [NUM_CH-1:0] chGrant,
  input logic              abortPulse
);

  // Independent shadow of the threshold, built from the write port
  logic [LVL_W-1:0] shadowLvl;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       shadowLvl <= {LVL_W{1'b1}};
    else if (cfgWrEn) shadowLvl <= cfgWrData;
  end
  logic vetoed;
  assign vetoed = irqValid && (irqLevel < shadowLvl);

  p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chGrant));

  p_grant_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|chGrant) && !xferDone && !xferBreak) |=> (chGrant == $past(chGrant)));

  p_grant_under_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|chGrant) |-> holdReq);

  p_release_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(holdReq) |=> !holdReq);

  p_idle_veto_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!holdReq && vetoed) |=> !holdReq);

  p_abort_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abortPulse |=> !abortPulse);

  p_abort_from_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abortPulse |-> (!holdReq && $past(|chGrant)));

endmodule

bind dma_hold_arbiter dma_hold_arbiter_chk #(
  .NUM_CH (NUM_CH),
  .LVL_W  (LVL_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .xferDone   (xferDone),
  .xferBreak  (xferBreak),
  .irqValid   (irqValid),
  .irqLevel   (irqLevel),
  .cfgWrEn    (cfgWrEn),
  .cfgWrData  (cfgWrData),
  .holdReq    (holdReq),
  .chGrant    (chGrant),
  .abortPulse (abortPulse)
);

// File: tb/dma_hold_arbiter_tb_top.sv
module dma_hold_arbiter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 8;
  localparam int LVL_W  = 5;
  localparam int CH_W   = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NUM_CH-1:0] chReq = '0;
  logic              holdAck = 1'b0;
  logic              xferDone = 1'b0;
  logic              xferBreak = 1'b0;
  logic              irqValid = 1'b0;
  logic [LVL_W-1:0]  irqLevel = '0;
  logic              cfgWrEn = 1'b0;
  logic [LVL_W-1:0]  cfgWrData = '0;
  logic              holdReq;
  logic [NUM_CH-1:0] chGrant;
  logic              abortPulse;
  logic [CH_W-1:0]   abortCh;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_hold_arbiter #(.NUM_CH(NUM_CH), .LVL_W(LVL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .chReq(chReq), .holdAck(holdAck),
    .xferDone(xferDone), .xferBreak(xferBreak), .irqValid(irqValid),
    .irqLevel(irqLevel), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .holdReq(holdReq), .chGrant(chGrant), .abortPulse(abortPulse),
    .abortCh(abortCh)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok || act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Finish the current transfer and return to idle
  task automatic endXfer();
    xferDone = 1'b1;
    tick();
    xferDone = 1'b0;
    holdAck  = 1'b0;
    tick();
    tick();
  endtask

  task automatic t_reset();
    check(1, "R1 holdReq", int'(holdReq), 0);
    check(1, "R1 chGrant", int'(chGrant), 0);
    check(1, "R1 abortPulse", int'(abortPulse), 0);
  endtask

  task automatic t_priority();
    chReq = 8'b1010_0100;
    tick();
    check(1, "R4 holdReq raised", int'(holdReq), 1);
    check(1, "R4 no grant before ack", int'(chGrant), 0);
    holdAck = 1'b1;
    tick();
    check(1, "R2 lowest index granted", int'(chGrant), 'h04);
    chReq = 8'b1010_0101;
    tick();
    check(1, "R3 grant locked", int'(chGrant), 'h04);
    xferDone = 1'b1;
    tick();
    xferDone = 1'b0;
    check(1, "R5 hold dropped", int'(holdReq), 0);
    check(1, "R5 grant dropped", int'(chGrant), 0);
    tick();
    check(1, "R5 waits for ack low", int'(holdReq), 0);
    holdAck = 1'b0;
    tick();
    check(1, "R5 idle gap", int'(holdReq), 0);
    tick();
    check(1, "R5 next hold", int'(holdReq), 1);
    holdAck = 1'b1;
    tick();
    check(1, "R2 channel 0 wins", int'(chGrant), 'h01);
    chReq = '0;
    endXfer();
  endtask

  task automatic t_reset_level();
    chReq = 8'h08; irqValid = 1'b1; irqLevel = 5'd30;
    repeat (3) tick();
    check(1, "R8 level 30 vetoes after reset", int'(holdReq), 0);
    irqLevel = 5'd31;
    tick();
    check(1, "R8 level 31 no veto", int'(holdReq), 1);
    holdAck = 1'b1;
    tick();
    check(1, "R8 grant ch3", int'(chGrant), 'h08);
    chReq = '0; irqValid = 1'b0;
    endXfer();
  endtask

  task automatic t_irq_invalid();
    irqValid = 1'b0; irqLevel = 5'd0; chReq = 8'h80;
    tick();
    check(1, "R9 invalid level ignored", int'(holdReq), 1);
    holdAck = 1'b1;
    tick();
    check(1, "R9 grant ch7", int'(chGrant), 'h80);
    chReq = '0;
    endXfer();
  endtask

  task automatic t_written_level();
    cfgWrEn = 1'b1; cfgWrData = 5'd10;
    tick();
    cfgWrEn = 1'b0;
    irqValid = 1'b1; irqLevel = 5'd10; chReq = 8'h40;
    tick();
    check(1, "R6 equal level no veto", int'(holdReq), 1);
    holdAck = 1'b1;
    tick();
    chReq = '0;
    endXfer();
    irqLevel = 5'd9; chReq = 8'h40;
    repeat (2) tick();
    check(1, "R6 more urgent vetoes", int'(holdReq), 0);
    irqValid = 1'b0;
    tick();
    check(1, "R9 veto lifts", int'(holdReq), 1);
    holdAck = 1'b1;
    tick();
    chReq = '0;
    endXfer();
  endtask

  task automatic t_cancel();
    irqValid = 1'b1; irqLevel = 5'd20; chReq = 8'h20;
    tick();
    holdAck = 1'b1;
    tick();
    check(1, "R7 grant ch5", int'(chGrant), 'h20);
    xferBreak = 1'b1;
    tick();
    check(1, "R7 break without veto ignored", int'(chGrant), 'h20);
    xferBreak = 1'b0; irqLevel = 5'd3;
    tick();
    check(1, "R7 veto waits for break", int'(chGrant), 'h20);
    xferBreak = 1'b1;
    tick();
    xferBreak = 1'b0;
    check(1, "R7 hold released", int'(holdReq), 0);
    check(1, "R7 grant removed", int'(chGrant), 0);
    check(1, "R7 abort pulse", int'(abortPulse), 1);
    check(1, "R7 abort channel", int'(abortCh), 5);
    holdAck = 1'b0;
    tick();
    check(1, "R7 abort one cycle", int'(abortPulse), 0);
    repeat (3) tick();
    check(1, "R6 held request stays off bus", int'(holdReq), 0);
    irqValid = 1'b0;
    tick();
    check(1, "R10 hold again after veto", int'(holdReq), 1);
    holdAck = 1'b1;
    tick();
    check(1, "R10 ch5 regranted", int'(chGrant), 'h20);
    chReq = '0;
    endXfer();
  endtask

  task automatic t_withdraw();
    irqValid = 1'b0; chReq = 8'h02;
    tick();
    check(1, "R11 hold raised", int'(holdReq), 1);
    irqValid = 1'b1; irqLevel = 5'd3;
    tick();
    check(1, "R11 hold withdrawn", int'(holdReq), 0);
    check(1, "R11 no abort", int'(abortPulse), 0);
    irqValid = 1'b0; chReq = '0;
    tick();
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_priority();
    t_reset_level();
    t_irq_invalid();
    t_written_level();
    t_cancel();
    t_withdraw();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule